// File: doc/BRIEF.md
# Serial Peripheral Interface Controller

This block is a byte-wide SPI controller that software drives through four small registers. In master mode a write to the data register starts a frame of 1 to 8 bits. The block generates SCK from the system clock through a programmable divider, drives MOSI and samples MISO. In slave mode it shifts 8-bit frames clocked by an external SCK while NSS is low. It returns the byte it holds on MISO and collects MOSI.

Clock polarity and clock phase are set in software. The frame-end flag and three sticky error flags (write collision, mode fault, receive overrun) share one interrupt line. A read-only field shows how many bits of the current frame have already been shifted. Received words go to a single holding register. A new word is written into it only after software has read the previous one.

Top module: `spi_port`

## Requirements
- R1: SCK sits at the polarity level (config bit 1) whenever no master frame is running. It also sits there while the block is disabled.
- R2: In master mode the receive side samples MISO on the edge that the phase bit (config bit 0) selects: the leading edge for 0 and the trailing edge for 1. With MOSI looped back to MISO, the word read back equals the word sent, for every polarity and phase.
- R3: A frame-size code c (config bits 4:2) gives c+1 bits per master frame and 2(c+1) SCK edges. The low c+1 bits of the written word go out most significant first, and the received bits fill the low c+1 bits of the read word.
- R4: Each SCK half period lasts N+1 system clocks, where N is the rate register. The busy flag stays high for exactly 2(c+1)(N+1) cycles.
- R5: Register map: address 0 is data, 1 is control/status, 2 is config, 3 is rate. Control/status bits are: 0 enable, 1 master, 2 frame done, 3 write collision, 4 mode fault, 5 overrun, 6 busy (read-only), 7 selected (read-only). After reset all registers read 0. In master mode a data write starts a frame, and a data read returns the receive holding register.
- R6: Frame done is set when a frame ends. Writing 0 to its bit clears it, and writing 1 leaves it set.
- R7: A data write during a frame sets the write-collision flag. The written byte is discarded, and the frame in progress still completes with its original word.
- R8: NSS low while master mode and enable are both set raises the mode-fault flag. The flag stays set until software clears it.
- R9: When a frame ends while the holding register is unread, the overrun flag is set and the older byte is kept.
- R10: The interrupt output is high exactly while any of frame done, collision, fault or overrun is set.
- R11: Config bits 7:5 show the number of bits already shifted in the running frame.
- R12: In slave mode frames are always 8 bits, whatever the size code. MISO carries the preloaded word most significant first, and status bit 7 shows NSS low.
- R13: Clearing enable aborts a running frame at once: busy drops, SCK returns to idle, and no done flag follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (a read at address 0 frees the holding register) |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data for addr_i |
| irq_o | output | 1 | Interrupt request |
| sck_o | output | 1 | SCK driven in master mode |
| sck_i | input | 1 | SCK received in slave mode |
| mosi_o | output | 1 | Serial data out in master mode |
| mosi_i | input | 1 | Serial data in in slave mode |
| miso_o | output | 1 | Serial data out in slave mode while selected |
| miso_i | input | 1 | Serial data in in master mode |
| nss_i | input | 1 | Slave select input, active low |

## Verification
The assertions assume that software does not change the master bit, the polarity or the size code while a frame is running. Every bench step reconfigures only after busy has fallen or after disabling. The slave checks also assume that each external SCK level lasts several system clocks, longer than the input synchronizer. The bench holds each level for at least eight cycles and changes MOSI well away from the sampling edges. Mode-fault stimulus holds NSS low or high for several cycles, so the synchronized value settles before the flags are read.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_CTRL = 2'd1,
    REG_CFG  = 2'd2,
    REG_RATE = 2'd3
  } spi_reg_e;

  // control/status bit positions
  localparam int CB_EN   = 0;
  localparam int CB_MST  = 1;
  localparam int CB_DONE = 2;
  localparam int CB_WCOL = 3;
  localparam int CB_MODF = 4;
  localparam int CB_OVR  = 5;

  // config bit positions
  localparam int FB_CPHA = 0;
  localparam int FB_CPOL = 1;
  localparam int FB_SIZE = 2;

  localparam int NUM_FLAGS = 4;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= {STAGES{RST_VAL}};
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/spi_rate_div.sv
module spi_rate_div #(
  parameter int RATE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              tick_o
);
  logic [RATE_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == rate_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_flag_cell.sv
module spi_flag_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // hardware set wins over a same-cycle software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              master_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic [CNT_W-1:0]  size_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              tick_i,
  input  logic              sel_i,
  input  logic              sck_s_i,
  input  logic              din_i,
  output logic              busy_o,
  output logic              active_o,
  output logic              sck_o,
  output logic              dout_o,
  output logic              done_o,
  output logic [DATA_W-1:0] word_o,
  output logic [CNT_W-1:0]  shifted_o
);
  localparam int NB_W = CNT_W + 1;

  logic [DATA_W-1:0] sr_q, sr_nxt, load_val;
  logic [NB_W-1:0]   nbits, nshift_q;
  logic [DATA_W:0]   mask_w;
  logic              phase_q, rxb_q, have_q, sck_prev_q;
  logic              sck_n, s_lead, s_trail, ev, lead, samp_ev, shft_ev, last;
  logic              fin_samp, fin_shft;

  assign nbits    = master_i ? NB_W'(size_i) + NB_W'(1) : NB_W'(DATA_W);
  assign load_val = load_data_i << (NB_W'(DATA_W) - nbits);
  assign mask_w   = ((DATA_W+1)'(1) << nbits) - (DATA_W+1)'(1);

  // slave edges, normalised so "leading" means leaving idle level
  assign sck_n   = sck_s_i ^ cpol_i;
  assign s_lead  = en_i && !master_i && sel_i && sck_n && !sck_prev_q;
  assign s_trail = en_i && !master_i && sel_i && !sck_n && sck_prev_q;

  assign ev      = master_i ? (busy_o && tick_i) : (s_lead || s_trail);
  assign lead    = master_i ? !phase_q : s_lead;
  assign samp_ev = ev && (lead ^ cpha_i);
  assign shft_ev = ev && !(lead ^ cpha_i);
  assign last    = (nshift_q == nbits - NB_W'(1));

  assign fin_samp = samp_ev && cpha_i && last;
  assign fin_shft = shft_ev && have_q && !cpha_i && last;
  assign done_o   = fin_samp || fin_shft;

  always_comb begin
    sr_nxt = sr_q;
    if (fin_samp)               sr_nxt = {sr_q[DATA_W-2:0], din_i};
    else if (shft_ev && have_q) sr_nxt = {sr_q[DATA_W-2:0], rxb_q};
  end

  assign word_o    = sr_nxt & mask_w[DATA_W-1:0];
  assign active_o  = master_i ? busy_o : (sel_i && (nshift_q != '0 || have_q));
  assign sck_o     = (master_i && en_i) ? (cpol_i ^ phase_q) : cpol_i;
  assign dout_o    = sr_q[DATA_W-1];
  assign shifted_o = nshift_q[CNT_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q       <= '0;
      nshift_q   <= '0;
      phase_q    <= 1'b0;
      rxb_q      <= 1'b0;
      have_q     <= 1'b0;
      busy_o     <= 1'b0;
      sck_prev_q <= 1'b0;
    end else begin
      sck_prev_q <= sck_n;
      if (!en_i) begin
        busy_o   <= 1'b0;
        phase_q  <= 1'b0;
        nshift_q <= '0;
        have_q   <= 1'b0;
      end else begin
        if (!master_i && !sel_i) begin
          nshift_q <= '0;
          have_q   <= 1'b0;
        end
        if (load_i && !active_o) begin
          sr_q <= load_val;
          if (master_i) begin
            busy_o  <= 1'b1;
            phase_q <= 1'b0;
          end
        end else begin
          sr_q <= sr_nxt;
          if (master_i && busy_o && tick_i) phase_q <= ~phase_q;
          if (samp_ev && !fin_samp) begin
            rxb_q  <= din_i;
            have_q <= 1'b1;
          end
          if (shft_ev && have_q) begin
            have_q   <= 1'b0;
            nshift_q <= nshift_q + NB_W'(1);
          end
          if (done_o) begin
            nshift_q <= '0;
            have_q   <= 1'b0;
            busy_o   <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int RATE_W = 8,
  parameter int SYNC_N = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic       rd_en_i,
  input  logic [1:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       irq_o,
  output logic       sck_o,
  input  logic       sck_i,
  output logic       mosi_o,
  input  logic       mosi_i,
  output logic       miso_o,
  input  logic       miso_i,
  input  logic       nss_i
);
  localparam int CNT_W = $clog2(DATA_W);

  logic              en_q, mst_q, cpol_q, cpha_q;
  logic [CNT_W-1:0]  size_q, shifted;
  logic [RATE_W-1:0] rate_q;
  logic [DATA_W-1:0] rx_buf_q, word;
  logic              rx_full_q;
  logic              nss_s, sck_s, sel, tick;
  logic              core_busy, core_active, core_done, dout, din;
  logic              data_wr, data_rd, ctrl_wr;
  logic [NUM_FLAGS-1:0] flag_set, flag_clr, flags;

  assign data_wr = wr_en_i && spi_reg_e'(addr_i) == REG_DATA;
  assign data_rd = rd_en_i && spi_reg_e'(addr_i) == REG_DATA;
  assign ctrl_wr = wr_en_i && spi_reg_e'(addr_i) == REG_CTRL;

  spi_sync #(.STAGES(SYNC_N), .RST_VAL(1'b1)) u_nss_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(nss_i), .q_o(nss_s));
  spi_sync #(.STAGES(SYNC_N), .RST_VAL(1'b0)) u_sck_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sck_i), .q_o(sck_s));

  assign sel = !nss_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      mst_q  <= 1'b0;
      cpol_q <= 1'b0;
      cpha_q <= 1'b0;
      size_q <= '0;
      rate_q <= '0;
    end else if (wr_en_i) begin
      unique case (spi_reg_e'(addr_i))
        REG_CTRL: begin
          en_q  <= wdata_i[CB_EN];
          mst_q <= wdata_i[CB_MST];
        end
        REG_CFG: begin
          cpha_q <= wdata_i[FB_CPHA];
          cpol_q <= wdata_i[FB_CPOL];
          size_q <= wdata_i[FB_SIZE +: CNT_W];
        end
        REG_RATE: rate_q <= wdata_i[RATE_W-1:0];
        default: ;
      endcase
    end
  end

  spi_rate_div #(.RATE_W(RATE_W)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(core_busy && mst_q),
    .rate_i(rate_q), .tick_o(tick));

  assign din = mst_q ? miso_i : mosi_i;

  spi_shift_core #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_q), .master_i(mst_q),
    .cpol_i(cpol_q), .cpha_i(cpha_q), .size_i(size_q),
    .load_i(data_wr), .load_data_i(wdata_i[DATA_W-1:0]), .tick_i(tick),
    .sel_i(sel), .sck_s_i(sck_s), .din_i(din),
    .busy_o(core_busy), .active_o(core_active), .sck_o(sck_o),
    .dout_o(dout), .done_o(core_done), .word_o(word), .shifted_o(shifted));

  // receive holding register: older unread byte is kept on overrun
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_buf_q  <= '0;
      rx_full_q <= 1'b0;
    end else if (core_done && (!rx_full_q || data_rd)) begin
      rx_buf_q  <= word;
      rx_full_q <= 1'b1;
    end else if (data_rd) begin
      rx_full_q <= 1'b0;
    end
  end

  // flag order: 0 done, 1 collision, 2 fault, 3 overrun
  assign flag_set[0] = core_done;
  assign flag_set[1] = data_wr && en_q && core_active;
  assign flag_set[2] = en_q && mst_q && !nss_s;
  assign flag_set[3] = core_done && rx_full_q && !data_rd;

  genvar g;
  generate
    for (g = 0; g < NUM_FLAGS; g++) begin : g_flag
      assign flag_clr[g] = ctrl_wr && !wdata_i[CB_DONE + g];
      spi_flag_cell u_cell (
        .clk_i(clk_i), .rst_ni(rst_ni), .set_i(flag_set[g]),
        .clr_i(flag_clr[g]), .q_o(flags[g]));
    end
  endgenerate

  assign irq_o = |flags;

  always_comb begin
    unique case (spi_reg_e'(addr_i))
      REG_DATA: rdata_o = 8'(rx_buf_q);
      REG_CTRL: rdata_o = {sel, core_busy && mst_q, flags, mst_q, en_q};
      REG_CFG:  rdata_o = 8'({shifted, size_q, cpol_q, cpha_q});
      default:  rdata_o = 8'(rate_q);
    endcase
  end

  assign mosi_o = (en_q && mst_q) ? dout : 1'b0;
  assign miso_o = (en_q && !mst_q && sel) ? dout : 1'b0;
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk #(
  parameter int CNT_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sck_o,
  input logic             irq_o,
  input logic             core_busy,
  input logic             mst_q,
  input logic             en_q,
  input logic             cpol_q,
  input logic             data_wr,
  input logic [CNT_W-1:0] size_q,
  input logic [CNT_W-1:0] shifted,
  input logic [3:0]       flags,
  input logic [3:0]       flag_clr
);
  // R1
  idle_sck_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !core_busy |-> sck_o == cpol_q);

  // R11
  shift_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_busy && mst_q) |-> shifted <= size_q);

  // R13
  abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |=> !core_busy);

  // R5
  start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(core_busy) |-> $past(data_wr));

  // R6
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags[0] && !flag_clr[0]) |=> flags[0]);

  // R8
  fault_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags[2] && !flag_clr[2]) |=> flags[2]);

  // R9
  ovr_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags[3] && !flag_clr[3]) |=> flags[3]);

  // R10
  irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags[1]) |-> irq_o);
endmodule

bind spi_port spi_port_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sck_o(sck_o), .irq_o(irq_o),
  .core_busy(core_busy), .mst_q(mst_q), .en_q(en_q), .cpol_q(cpol_q),
  .data_wr(data_wr), .size_q(size_q), .shifted(shifted),
  .flags(flags), .flag_clr(flag_clr));

// File: tb/spi_port_test.sv
module spi_port_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00, rdata;
  logic irq, sck_o, sck_i = 1'b0, mosi_o, mosi_i = 1'b0, miso_o, miso_i, nss = 1'b1;
  int chk_cnt = 0, fail_cnt = 0;
  bit finished = 1'b0;

  assign miso_i = mosi_o; // loopback for master tests

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_port uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq),
    .sck_o(sck_o), .sck_i(sck_i), .mosi_o(mosi_o), .mosi_i(mosi_i),
    .miso_o(miso_o), .miso_i(miso_i), .nss_i(nss));

  // {cpol, cpha, size code, rate, data}
  localparam logic [20:0] VEC [6] = '{
    {1'b0, 1'b0, 3'd7, 8'd0, 8'hA5},
    {1'b1, 1'b0, 3'd7, 8'd2, 8'h3C},
    {1'b0, 1'b1, 3'd3, 8'd1, 8'h9E},
    {1'b1, 1'b1, 3'd0, 8'd0, 8'h01},
    {1'b0, 1'b1, 3'd4, 8'd3, 8'hD7},
    {1'b1, 1'b0, 3'd5, 8'd0, 8'h6B}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    chk_cnt++;
    if (act !== exp) begin
      fail_cnt++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic pop(output logic [7:0] d);
    @(negedge clk);
    addr = 2'd0; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int i = 0; i < 4000; i++) begin
      peek(2'd1, s);
      if (!s[6]) break;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      chk_cnt++; fail_cnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", chk_cnt - fail_cnt, chk_cnt);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, s;
    repeat (3) @(negedge clk);
    // reset state
    peek(2'd0, d); check("R5 reset data", d, 8'h00);
    peek(2'd1, d); check("R5 reset ctrl", d, 8'h00);
    peek(2'd2, d); check("R5 reset cfg", d, 8'h00);
    peek(2'd3, d); check("R5 reset rate", d, 8'h00);
    check("R10 reset irq", irq, 1'b0);
    check("R1 reset sck", sck_o, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // table of master frames with loopback
    foreach (VEC[k]) begin
      logic cpol, cpha, prev_sck, mosi_prev;
      logic [2:0] code;
      logic [7:0] rate, dat, mask, cap;
      int n, busy_cnt, toggles;
      {cpol, cpha, code, rate, dat} = VEC[k];
      n = int'(code) + 1;
      mask = 8'((9'd1 << n) - 9'd1);
      wr(2'd2, {3'b000, code, cpol, cpha});
      wr(2'd3, rate);
      wr(2'd1, 8'h03);
      check("R1 idle before frame", sck_o, cpol);
      prev_sck = sck_o;
      wr_en = 1'b1; addr = 2'd0; wdata = dat;
      @(negedge clk);
      wr_en = 1'b0;
      busy_cnt = 0; toggles = 0; cap = 8'h00;
      mosi_prev = mosi_o;
      for (int i = 0; i < 4000; i++) begin
        peek(2'd1, s);
        if (sck_o != prev_sck) begin
          if ((toggles % 2) == int'(cpha)) cap = {cap[6:0], mosi_prev};
          toggles++;
          prev_sck = sck_o;
        end
        if (!s[6]) break;
        busy_cnt++;
        mosi_prev = mosi_o;
        @(negedge clk);
      end
      check("R4 busy cycles", busy_cnt, 2 * n * (int'(rate) + 1));
      check("R3 sck edges", toggles, 2 * n);
      check("R3 msb-first bits", cap & mask, dat & mask);
      check("R1 idle after frame", sck_o, cpol);
      check("R6 done set", s[2], 1'b1);
      check("R10 irq on done", irq, 1'b1);
      pop(d);
      check("R2 loopback word", d, dat & mask);
      wr(2'd1, 8'h03);
      check("R6 done cleared by 0", irq, 1'b0);
    end

    // live shift count
    wr(2'd2, {3'b000, 3'd7, 1'b0, 1'b0});
    wr(2'd3, 8'd3);
    wr_en = 1'b1; addr = 2'd0; wdata = 8'h5A;
    @(negedge clk);
    wr_en = 1'b0;
    repeat (27) @(negedge clk);
    peek(2'd2, d);
    check("R11 bits shifted", d[7:5], 3'd3);
    wait_idle();
    pop(d);
    check("R2 word after count test", d, 8'h5A);
    wr(2'd1, 8'h03);

    // write collision
    wr(2'd0, 8'h81);
    repeat (10) @(negedge clk);
    wr(2'd0, 8'h42);
    peek(2'd1, s);
    check("R7 collision flag", s[3], 1'b1);
    check("R10 irq on collision", irq, 1'b1);
    wait_idle();
    peek(2'd1, s);
    check("R7 frame completes", s[2], 1'b1);
    wr(2'd1, 8'h03);

    // overrun: holding register still has the unread 0x81
    wr(2'd0, 8'h55);
    @(negedge clk);
    wait_idle();
    peek(2'd1, s);
    check("R9 overrun flag", s[5], 1'b1);
    pop(d);
    check("R9 R7 older byte kept", d, 8'h81);
    wr(2'd1, 8'h03);
    peek(2'd1, s);
    check("R10 all flags cleared", {irq, s}, {1'b0, 8'h03});

    // writing 1 leaves done set
    wr(2'd3, 8'd0);
    wr(2'd0, 8'h11);
    @(negedge clk);
    wait_idle();
    wr(2'd1, 8'h07);
    peek(2'd1, s);
    check("R6 write 1 keeps done", s[2], 1'b1);
    pop(d);
    wr(2'd1, 8'h03);
    peek(2'd1, s);
    check("R6 write 0 clears done", s[2], 1'b0);

    // abort by disable
    wr(2'd2, {3'b000, 3'd7, 1'b1, 1'b0});
    wr(2'd3, 8'd10);
    wr(2'd0, 8'h99);
    repeat (30) @(negedge clk);
    wr(2'd1, 8'h00);
    peek(2'd1, s);
    check("R13 busy dropped", s[6], 1'b0);
    check("R13 sck idle", sck_o, 1'b1);
    repeat (300) @(negedge clk);
    peek(2'd1, s);
    check("R13 no done after abort", s[2], 1'b0);

    // mode fault
    wr(2'd2, 8'h00);
    wr(2'd1, 8'h03);
    nss = 1'b0;
    repeat (4) @(negedge clk);
    peek(2'd1, s);
    check("R8 mode fault", s[4], 1'b1);
    check("R10 irq on fault", irq, 1'b1);
    nss = 1'b1;
    repeat (4) @(negedge clk);
    peek(2'd1, s);
    check("R8 fault sticky", s[4], 1'b1);
    wr(2'd1, 8'h03);
    repeat (4) @(negedge clk);
    peek(2'd1, s);
    check("R8 fault cleared", s[4], 1'b0);

    // slave frame, size code 000 ignored
    begin
      logic [7:0] pat, cap;
      pat = 8'h3A; cap = 8'h00;
      wr(2'd1, 8'h01);
      wr(2'd2, 8'h00);
      wr(2'd0, 8'hC6);
      nss = 1'b0;
      repeat (4) @(negedge clk);
      peek(2'd1, s);
      check("R12 selected flag", s[7], 1'b1);
      for (int i = 7; i >= 0; i--) begin
        mosi_i = pat[i];
        repeat (4) @(negedge clk);
        cap = {cap[6:0], miso_o};
        sck_i = 1'b1;
        repeat (8) @(negedge clk);
        sck_i = 1'b0;
        repeat (4) @(negedge clk);
      end
      repeat (6) @(negedge clk);
      peek(2'd1, s);
      check("R12 slave done", s[2], 1'b1);
      check("R12 miso msb-first", cap, 8'hC6);
      pop(d);
      check("R12 eight bits received", d, pat);
      nss = 1'b1;
      repeat (4) @(negedge clk);
      peek(2'd1, s);
      check("R12 deselected", s[7], 1'b0);
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", chk_cnt - fail_cnt, chk_cnt);
    $finish;
  end
endmodule